// File: doc/BRIEF.md
# Modulator Bitstream Bypass Clock Generator

This block sits at the output edge of a multi-channel delta-sigma converter's digital core. It lets the raw single-bit modulator streams leave the chip without passing through the decimation filter. While the 3-bit format input holds the bypass code, three things change. Each channel's data pin carries that channel's modulator bit. The serial clock pin turns from an input into an output and drives a modulator clock divided from the master clock. The filter-enable output drops low. For any other format code the block is transparent: the normal-path data and ready signals pass straight to the pins, and the serial clock stays undriven.

The division ratio comes from a 2-bit speed mode and a 1-bit divide select. The generated clock always has a 50% duty cycle. A small state machine produces it:

- **ST_IDLE** is normal mode. It moves to **ST_LOW** when the bypass code appears (*enter*).
- **ST_LOW** moves to **ST_HIGH** after a full half period (*rise*).
- **ST_HIGH** moves back to **ST_LOW** after a full half period (*fall*).
- A change of ratio in either running state sends the machine to **ST_LOW** with the counter cleared (*restart*).
- Leaving the bypass code from either running state returns the machine to **ST_IDLE** (*exit*).

The held modulator bits are reloaded on *enter* and on every move from ST_HIGH to ST_LOW. They therefore change only where the generated clock falls, and they are steady at its next rising edge.

Top module: `modbyp_clkgen`

## Requirements
- R1: While the format input is not 3'b110, `data_o` equals `norm_data_i`, `rdy_o` equals `norm_rdy_i`, `sclk_oe_o` is 0, `sclk_o` is 0 and `filt_en_o` is 1.
- R2: Bypass mode starts on the clock edge after the format input becomes 3'b110 and ends on the edge after it leaves that code. While bypass is active, `sclk_oe_o` is 1 and `filt_en_o` is 0.
- R3: While bypass is active, `rdy_o` is held at 0 whatever `norm_rdy_i` does.
- R4: In bypass with speed mode 2'b00 or 2'b01, `sclk_o` has a period of 4 master cycles, whatever the divide select.
- R5: With speed mode 2'b10, the period is 8 master cycles when the divide select is 1 and 4 when it is 0.
- R6: With speed mode 2'b11, the period is 40 master cycles when the divide select is 1 and 8 when it is 0.
- R7: For every ratio, `sclk_o` is high for exactly half the period and low for the other half.
- R8: In bypass, bit k of `data_o` carries channel k's modulator bit. It changes only on a master edge where `sclk_o` falls, or on the entry edge. The value it takes is `mod_bits_i` as sampled at that edge.
- R9: On entry to bypass, and whenever the selected ratio changes while in bypass, `sclk_o` goes or stays low for exactly one new half period counted from that edge, then runs at the new ratio.
- R10: During and right after reset, `sclk_o` is 0, `sclk_oe_o` is 0, `filt_en_o` is 1 and `data_o` is the normal path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| fmt_sel_i | input | 3 | Output format select; 3'b110 picks bypass |
| rate_mode_i | input | 2 | Speed mode used in the ratio decode |
| div_sel_i | input | 1 | Clock-divide select used in the ratio decode |
| mod_bits_i | input | NCH | One modulator bit per channel |
| norm_data_i | input | NCH | Normal-path per-channel data |
| norm_rdy_i | input | 1 | Normal-path ready / frame-sync level |
| data_o | output | NCH | Per-channel data pins |
| sclk_o | output | 1 | Generated modulator clock, valid when enabled |
| sclk_oe_o | output | 1 | Output enable of the serial clock pin |
| rdy_o | output | 1 | Ready / frame-sync pin |
| filt_en_o | output | 1 | Decimation filter enable |

## Verification
Each ratio is entered fresh from normal mode, so that the first low run and the following high and low runs can be compared with the expected half period. This separates /4, /8 and /40, and catches a wrong duty cycle. Ratio changes are made in flight: one during a high phase and one partway through a low phase. The low phase case shows whether the counter restarts or carries the old count. The modulator inputs change every master cycle during bypass, so a design that updates data away from the falling edge, or samples the wrong cycle, is exposed. Normal mode is tried with several format codes next to the bypass code, to show that only 3'b110 switches the pins.

// File: rtl/modbyp_pkg.sv
package modbyp_pkg;

    localparam logic [2:0] FMT_BYPASS = 3'b110;
    localparam int HALF_FAST = 2;
    localparam int HALF_MID  = 4;
    localparam int HALF_SLOW = 20;
    localparam int HALF_MAX  = HALF_SLOW;
    localparam int CNT_W     = $clog2(HALF_MAX + 1);

    typedef logic [CNT_W-1:0] half_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOW  = 2'd1,
        ST_HIGH = 2'd2
    } clk_state_e;

    // Half period, in master cycles, of the generated modulator clock.
    function automatic half_t half_of(input logic [1:0] mode, input logic div);
        half_t h;
        case (mode)
            2'b10:   h = div ? half_t'(HALF_MID)  : half_t'(HALF_FAST);
            2'b11:   h = div ? half_t'(HALF_SLOW) : half_t'(HALF_MID);
            default: h = half_t'(HALF_FAST);
        endcase
        return h;
    endfunction

endpackage

// File: rtl/modbyp_ratio_dec.sv
module modbyp_ratio_dec
    import modbyp_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       div_i,
    output half_t      half_o
);

    always_comb begin
        half_o = half_of(mode_i, div_i);
    end

    // R5 R6: only the three legal half periods leave the decoder
    always_comb begin
        if (!$isunknown({mode_i, div_i}))
            a_r6_half_legal: assert (half_o == half_t'(HALF_FAST) ||
                                     half_o == half_t'(HALF_MID)  ||
                                     half_o == half_t'(HALF_SLOW));
    end

endmodule

// File: rtl/modbyp_divider.sv
module modbyp_divider
    import modbyp_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  byp_req_i,
    input  half_t half_i,
    output logic  active_o,
    output logic  phase_o,
    output logic  load_o
);

    clk_state_e state_q, state_d;
    half_t      cnt_q, cnt_d;
    half_t      half_q;
    logic       restart;
    logic       at_end;

    assign restart = (half_i != half_q);
    assign at_end  = ((cnt_q + half_t'(1)) == half_q);

    // next state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (byp_req_i) begin
                    state_d = ST_LOW;
                    cnt_d   = '0;
                end
            end
            ST_LOW: begin
                if (!byp_req_i) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (restart) begin
                    state_d = ST_LOW;
                    cnt_d   = '0;
                end else if (at_end) begin
                    state_d = ST_HIGH;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q + half_t'(1);
                end
            end
            ST_HIGH: begin
                if (!byp_req_i) begin
                    state_d = ST_IDLE;
                    cnt_d   = '0;
                end else if (restart || at_end) begin
                    state_d = ST_LOW;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q + half_t'(1);
                end
            end
            default: begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            half_q  <= half_t'(HALF_FAST);
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            half_q  <= half_i;
        end
    end

    // outputs
    always_comb begin
        active_o = (state_q != ST_IDLE);
        phase_o  = (state_q == ST_HIGH);
        load_o   = (state_d == ST_LOW) && (state_q != ST_LOW);
    end

    // R7: the counter never passes the half period in force
    a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_IDLE) |-> (cnt_q < half_q));

    // R9: a rise only follows a low phase that ran its full length
    a_r9_full_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_HIGH && $past(state_q) == ST_LOW)
        |-> (($past(cnt_q) + half_t'(1)) == $past(half_q)));

endmodule

// File: rtl/modbyp_bit_hold.sv
module modbyp_bit_hold #(
    parameter int NCH = 8
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           load_i,
    input  logic [NCH-1:0] bits_i,
    output logic [NCH-1:0] hold_o
);

    for (genvar k = 0; k < NCH; k++) begin : g_ch
        always_ff @(posedge clk_i) begin
            if (!rst_ni)
                hold_o[k] <= 1'b0;
            else if (load_i)
                hold_o[k] <= bits_i[k];
        end
    end

endmodule

// File: rtl/modbyp_pin_mux.sv
module modbyp_pin_mux #(
    parameter int NCH = 8
) (
    input  logic           active_i,
    input  logic           phase_i,
    input  logic [NCH-1:0] hold_i,
    input  logic [NCH-1:0] norm_data_i,
    input  logic           norm_rdy_i,
    output logic [NCH-1:0] data_o,
    output logic           sclk_o,
    output logic           sclk_oe_o,
    output logic           rdy_o,
    output logic           filt_en_o
);

    always_comb begin
        data_o    = active_i ? hold_i : norm_data_i;
        sclk_o    = active_i & phase_i;
        sclk_oe_o = active_i;
        rdy_o     = active_i ? 1'b0 : norm_rdy_i;
        filt_en_o = ~active_i;
    end

endmodule

// File: rtl/modbyp_clkgen.sv
module modbyp_clkgen
    import modbyp_pkg::*;
#(
    parameter int NCH = 8
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic [2:0]     fmt_sel_i,
    input  logic [1:0]     rate_mode_i,
    input  logic           div_sel_i,
    input  logic [NCH-1:0] mod_bits_i,
    input  logic [NCH-1:0] norm_data_i,
    input  logic           norm_rdy_i,
    output logic [NCH-1:0] data_o,
    output logic           sclk_o,
    output logic           sclk_oe_o,
    output logic           rdy_o,
    output logic           filt_en_o
);

    half_t          half;
    logic           byp_req;
    logic           active;
    logic           phase;
    logic           load;
    logic [NCH-1:0] hold;

    assign byp_req = (fmt_sel_i == FMT_BYPASS);

    modbyp_ratio_dec u_ratio (
        .mode_i (rate_mode_i),
        .div_i  (div_sel_i),
        .half_o (half)
    );

    modbyp_divider u_div (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .byp_req_i (byp_req),
        .half_i    (half),
        .active_o  (active),
        .phase_o   (phase),
        .load_o    (load)
    );

    modbyp_bit_hold #(.NCH(NCH)) u_hold (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load),
        .bits_i (mod_bits_i),
        .hold_o (hold)
    );

    modbyp_pin_mux #(.NCH(NCH)) u_mux (
        .active_i    (active),
        .phase_i     (phase),
        .hold_i      (hold),
        .norm_data_i (norm_data_i),
        .norm_rdy_i  (norm_rdy_i),
        .data_o      (data_o),
        .sclk_o      (sclk_o),
        .sclk_oe_o   (sclk_oe_o),
        .rdy_o       (rdy_o),
        .filt_en_o   (filt_en_o)
    );

    // R2: no clock level appears on a pin that is not driven
    a_r2_quiet_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !sclk_oe_o |-> !sclk_o);

    // R3: a high clock phase never coincides with a live ready pin or filter
    a_r3_rdy_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sclk_o |-> (!rdy_o && !filt_en_o));

    // R8: bypass data move only where the generated clock falls
    a_r8_data_on_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active && $past(active) && !($past(sclk_o) && !sclk_o)) |-> $stable(data_o));

endmodule

// File: tb/modbyp_clkgen_test.sv
`timescale 1ns/1ps
module modbyp_clkgen_test;

    localparam int NCH = 8;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [2:0]     fmt;
    logic [1:0]     mode;
    logic           div;
    logic [NCH-1:0] mod_bits;
    logic [NCH-1:0] norm_data;
    logic           norm_rdy;
    logic [NCH-1:0] data_o;
    logic           sclk_o, sclk_oe_o, rdy_o, filt_en_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    modbyp_clkgen #(.NCH(NCH)) uut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .fmt_sel_i   (fmt),
        .rate_mode_i (mode),
        .div_sel_i   (div),
        .mod_bits_i  (mod_bits),
        .norm_data_i (norm_data),
        .norm_rdy_i  (norm_rdy),
        .data_o      (data_o),
        .sclk_o      (sclk_o),
        .sclk_oe_o   (sclk_oe_o),
        .rdy_o       (rdy_o),
        .filt_en_o   (filt_en_o)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (sclk_o == lvl && n < 100) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic go_normal();
        @(negedge clk);
        fmt = 3'b000;
        @(negedge clk);
    endtask

    // R10: reset state
    task automatic t_reset();
        rst_n = 1'b0; fmt = 3'b110; mode = 2'b11; div = 1'b1;
        mod_bits = 8'hFF; norm_data = 8'h3C; norm_rdy = 1'b1;
        repeat (3) @(negedge clk);
        check(sclk_oe_o == 1'b0, "R10", "oe in reset", sclk_oe_o, 0);
        check(filt_en_o == 1'b1, "R10", "filter in reset", filt_en_o, 1);
        check(data_o == 8'h3C, "R10", "data in reset", data_o, 8'h3C);
        fmt = 3'b000;
        rst_n = 1'b1;
        @(negedge clk);
        check(sclk_o == 1'b0, "R10", "sclk after reset", sclk_o, 0);
        check(sclk_oe_o == 1'b0, "R10", "oe after reset", sclk_oe_o, 0);
    endtask

    // R1: normal pass-through for codes other than 3'b110
    task automatic t_normal();
        logic [2:0] codes [4] = '{3'b000, 3'b111, 3'b010, 3'b100};
        for (int i = 0; i < 4; i++) begin
            fmt = codes[i];
            norm_data = 8'(8'h5A ^ (i * 8'h33));
            norm_rdy = i[0];
            mod_bits = ~norm_data;
            @(negedge clk);
            @(negedge clk);
            check(data_o == norm_data, "R1", "pass data", data_o, norm_data);
            check(rdy_o == norm_rdy, "R1", "pass ready", rdy_o, norm_rdy);
            check(sclk_oe_o == 1'b0 && sclk_o == 1'b0, "R1", "sclk idle",
                  {sclk_oe_o, sclk_o}, 0);
            check(filt_en_o == 1'b1, "R1", "filter on", filt_en_o, 1);
        end
    endtask

    // R4 R5 R6 R7 R2 R3 R9: entry from normal, run lengths
    task automatic t_ratio(input logic [1:0] m, input logic d, input int h,
                           input string req);
        int n;
        go_normal();
        mode = m; div = d; norm_rdy = 1'b1;
        fmt = 3'b110;
        @(negedge clk);
        check(sclk_oe_o == 1'b1, "R2", "oe in bypass", sclk_oe_o, 1);
        check(filt_en_o == 1'b0, "R2", "filter off", filt_en_o, 0);
        check(rdy_o == 1'b0, "R3", "ready parked", rdy_o, 0);
        run_len(1'b0, n);
        check(n == h, "R9", "first low after entry", n, h);
        run_len(1'b1, n);
        check(n == h, req, "high run", n, h);
        run_len(1'b0, n);
        check(n == h, "R7", "low run", n, h);
        run_len(1'b1, n);
        check(n == h, req, "second high run", n, h);
    endtask

    // R9: ratio change restarts counter mid-phase
    task automatic t_restart();
        int n;
        go_normal();
        mode = 2'b11; div = 1'b1; fmt = 3'b110;
        @(negedge clk);
        run_len(1'b0, n);
        repeat (3) @(negedge clk);
        mode = 2'b00;
        @(negedge clk);
        check(sclk_o == 1'b0, "R9", "drop on change in high", sclk_o, 0);
        run_len(1'b0, n);
        check(n == 2, "R9", "new low after change", n, 2);
        run_len(1'b1, n);
        check(n == 2, "R4", "new high after change", n, 2);
        mode = 2'b11; div = 1'b1;
        @(negedge clk);
        run_len(1'b0, n);
        run_len(1'b1, n);
        repeat (5) @(negedge clk);
        div = 1'b0;
        @(negedge clk);
        run_len(1'b0, n);
        check(n == 4, "R9", "restart in low phase", n, 4);
        run_len(1'b1, n);
        check(n == 4, "R6", "high after low restart", n, 4);
    endtask

    // R8: data follow modulator bits only at falling edges
    task automatic t_data();
        logic [NCH-1:0] drv, expv;
        logic prev_s;
        go_normal();
        mode = 2'b10; div = 1'b1;
        drv = 8'hA7; mod_bits = drv; fmt = 3'b110;
        @(negedge clk);
        expv = drv;
        check(data_o == expv, "R8", "data at entry", data_o, expv);
        prev_s = sclk_o;
        drv = 8'h11; mod_bits = drv;
        for (int i = 0; i < 48; i++) begin
            @(negedge clk);
            if (prev_s && !sclk_o) expv = drv;
            check(data_o == expv, "R8", "bypass data", data_o, expv);
            prev_s = sclk_o;
            drv = 8'((i * 37 + 5) ^ (i << 3));
            mod_bits = drv;
        end
    endtask

    // R2 R1: leaving bypass restores the normal path
    task automatic t_exit();
        norm_data = 8'hC3; norm_rdy = 1'b1;
        @(negedge clk);
        fmt = 3'b111;
        @(negedge clk);
        check(sclk_oe_o == 1'b0, "R2", "oe after exit", sclk_oe_o, 0);
        check(sclk_o == 1'b0, "R2", "sclk after exit", sclk_o, 0);
        check(filt_en_o == 1'b1, "R2", "filter after exit", filt_en_o, 1);
        check(data_o == 8'hC3 && rdy_o == 1'b1, "R1", "normal after exit",
              {data_o, rdy_o}, {8'hC3, 1'b1});
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_ratio(2'b00, 1'b0, 2, "R4");
        t_ratio(2'b01, 1'b1, 2, "R4");
        t_ratio(2'b10, 1'b1, 4, "R5");
        t_ratio(2'b10, 1'b0, 2, "R5");
        t_ratio(2'b11, 1'b1, 20, "R6");
        t_ratio(2'b11, 1'b0, 4, "R6");
        t_restart();
        t_data();
        t_exit();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule